// File: doc/BRIEF.md
# Single-Accumulator Processor Core

This block is a small 16-bit processor built around one accumulator. It runs programs held in a single word-addressed memory that stores both code and data. Each instruction word carries a 4-bit operation code in bits 15:12 and a 12-bit operand address in bits 11:0, so the core can reach 4096 words. The core keeps a program counter, an accumulator and an instruction register. A small multi-cycle controller sequences them.

The memory sits outside the core. It is read combinationally: read data must reflect the current address within the same cycle. It is written on the rising clock edge while the write strobe is high. Every instruction has a fixed cycle cost:

- Jumps, no-operations and stop cost one cycle.
- Memory-operand instructions cost two cycles.
- The indexed add costs four cycles.

The fetch of the next instruction is folded into the last of those cycles. A free-running cycle counter stops together with the core, so a test program's cost can be read off directly. A halted output shows that execution has ended.

Top module: `acc_core`

## Requirements
- R1: While reset is high, halted is 0, the cycle counter is 0 and the write strobe is 0. In the first cycle after reset falls, the core fetches from address 0, and that cycle adds 1 to the cycle counter.
- R2: Opcode 0000 loads the word at the operand address into the accumulator and costs 2 cycles.
- R3: Opcode 0001 writes the accumulator to the operand address with the strobe high for exactly one cycle, and costs 2 cycles.
- R4: Opcode 0010 adds, and opcode 0011 subtracts, the word at the operand address to or from the accumulator. Both wrap modulo 2^16 and cost 2 cycles.
- R5: Opcode 0101 jumps to the operand address when accumulator bit 15 is 0, and otherwise continues in sequence. It costs 1 cycle either way.
- R6: Opcode 0100 always jumps. Opcode 0110 jumps only when the accumulator is nonzero. Both cost 1 cycle.
- R7: Opcode 0111 costs 1 cycle and raises halted. After that the core makes no writes, its address and the cycle counter stay frozen, and this lasts until reset.
- R8: Opcode 1000 reads a base word at address bits 11:6 and an index word at address bits 5:0, both zero-extended. It adds to the accumulator the word at the address formed by the low 12 bits of base plus index, and costs 4 cycles.
- R9: Opcodes 1001 to 1111 leave the accumulator and memory unchanged, continue in sequence and cost 1 cycle.
- R10: On halt, the cycle counter equals 1 (for the reset fetch) plus the sum of the costs of all instructions executed, the stop included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory word address for this cycle |
| mem_wdata | output | 16 | Data to write (the accumulator) |
| mem_we | output | 1 | Write strobe, memory writes at the clock edge |
| mem_rdata | input | 16 | Combinational read data for mem_addr |
| halted | output | 1 | High once a stop instruction has executed |
| cycle_count | output | CNT_W | Cycles spent since reset, frozen while halted |

## Verification
Faults in the accumulator, program counter or instruction register are not visible at the ports until the program stores a result or changes direction. The test programs therefore end every path with a store, which puts a corrupt accumulator on the write data within two cycles of the next store instruction. A wrong jump decision or a wrong controller phase shows up in two ways: the sequence of stores diverges, and the cycle count at halt differs from the summed budget. A wrong branch condition also puts a wrong address on the bus in the very cycle of the branch, so it is seen at once.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int DATA_W = 16;
    localparam int OPC_W  = 4;
    localparam int ADDR_W = 12;
    localparam int PTR_W  = ADDR_W / 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD   = 4'b0000,
        OP_STORE  = 4'b0001,
        OP_ADD    = 4'b0010,
        OP_SUB    = 4'b0011,
        OP_GOTO   = 4'b0100,
        OP_IFPOS  = 4'b0101,
        OP_IFNZ   = 4'b0110,
        OP_HALT   = 4'b0111,
        OP_IDXADD = 4'b1000
    } opcode_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        addr_t            field;
    } instr_t;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_EXEC,
        ST_FETCH,
        ST_PTR_IDX,
        ST_OPND,
        ST_HALT
    } state_e;

    typedef enum logic [1:0] {
        ALU_LOAD,
        ALU_ADD,
        ALU_SUB
    } alu_op_e;

    typedef enum logic [1:0] {
        JC_NONE,
        JC_ALWAYS,
        JC_NONNEG,
        JC_NONZERO
    } jcond_e;

    typedef enum logic [2:0] {
        CL_NOP,
        CL_MEM,
        CL_JUMP,
        CL_STOP,
        CL_INDEX
    } iclass_e;

    typedef struct packed {
        iclass_e cls;
        logic    store;
        alu_op_e alu;
        jcond_e  jc;
    } ctrl_t;

    function automatic ctrl_t decode_op(logic [OPC_W-1:0] opc);
        ctrl_t c;
        c = '{cls: CL_NOP, store: 1'b0, alu: ALU_LOAD, jc: JC_NONE};
        case (opc)
            OP_LOAD:   c.cls = CL_MEM;
            OP_STORE:  begin c.cls = CL_MEM; c.store = 1'b1; end
            OP_ADD:    begin c.cls = CL_MEM; c.alu = ALU_ADD; end
            OP_SUB:    begin c.cls = CL_MEM; c.alu = ALU_SUB; end
            OP_GOTO:   begin c.cls = CL_JUMP; c.jc = JC_ALWAYS; end
            OP_IFPOS:  begin c.cls = CL_JUMP; c.jc = JC_NONNEG; end
            OP_IFNZ:   begin c.cls = CL_JUMP; c.jc = JC_NONZERO; end
            OP_HALT:   c.cls = CL_STOP;
            OP_IDXADD: begin c.cls = CL_INDEX; c.alu = ALU_ADD; end
            default:   c.cls = CL_NOP;
        endcase
        return c;
    endfunction

    function automatic logic cond_met(jcond_e jc, word_t acc);
        case (jc)
            JC_ALWAYS:  return 1'b1;
            JC_NONNEG:  return ~acc[DATA_W-1];
            JC_NONZERO: return |acc;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic addr_t widen_ptr(ptr_t p);
        return {{(ADDR_W-PTR_W){1'b0}}, p};
    endfunction

endpackage

// File: rtl/acc_decoder.sv
module acc_decoder
    import acc_core_pkg::*;
(
    input  instr_t ir,
    input  word_t  acc,
    output ctrl_t  ctl,
    output logic   take_jump,
    output addr_t  base_addr,
    output addr_t  idx_addr
);
    always_comb begin
        ctl       = decode_op(ir.opc);
        take_jump = (ctl.cls == CL_JUMP) && cond_met(ctl.jc, acc);
        base_addr = widen_ptr(ir.field[ADDR_W-1:PTR_W]);
        idx_addr  = widen_ptr(ir.field[PTR_W-1:0]);
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_core_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/acc_sequencer.sv
module acc_sequencer
    import acc_core_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  iclass_e cls,
    output state_e  state
);
    state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_BOOT:    nxt = ST_EXEC;
            ST_EXEC: begin
                case (cls)
                    CL_STOP:  nxt = ST_HALT;
                    CL_MEM:   nxt = ST_FETCH;
                    CL_INDEX: nxt = ST_PTR_IDX;
                    default:  nxt = ST_EXEC;
                endcase
            end
            ST_FETCH:   nxt = ST_EXEC;
            ST_PTR_IDX: nxt = ST_OPND;
            ST_OPND:    nxt = ST_FETCH;
            ST_HALT:    nxt = ST_HALT;
            default:    nxt = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_BOOT;
        else     state <= nxt;
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    output logic [11:0]      mem_addr,
    output logic [15:0]      mem_wdata,
    output logic             mem_we,
    input  logic [15:0]      mem_rdata,
    output logic             halted,
    output logic [CNT_W-1:0] cycle_count
);
    state_e  state;
    instr_t  ir_q;
    word_t   acc_q;
    addr_t   pc_q;
    addr_t   ptr_q;
    ctrl_t   ctl;
    logic    take_jump;
    addr_t   base_addr;
    addr_t   idx_addr;
    alu_op_e alu_op;
    word_t   alu_y;
    logic    in_exec;
    logic    fetch_now;
    logic    acc_load;
    logic    [CNT_W-1:0] cnt_q;

    acc_decoder u_dec (
        .ir        (ir_q),
        .acc       (acc_q),
        .ctl       (ctl),
        .take_jump (take_jump),
        .base_addr (base_addr),
        .idx_addr  (idx_addr)
    );

    acc_sequencer u_seq (
        .clk   (clk),
        .rst   (rst),
        .cls   (ctl.cls),
        .state (state)
    );

    assign alu_op = (state == ST_OPND) ? ALU_ADD : ctl.alu;

    acc_alu #(.W(DATA_W)) u_alu (
        .op (alu_op),
        .a  (acc_q),
        .b  (mem_rdata),
        .y  (alu_y)
    );

    assign in_exec = (state == ST_EXEC);

    always_comb begin
        fetch_now = 1'b0;
        case (state)
            ST_BOOT, ST_FETCH: fetch_now = 1'b1;
            ST_EXEC: fetch_now = (ctl.cls == CL_NOP) || (ctl.cls == CL_JUMP);
            default: fetch_now = 1'b0;
        endcase
    end

    assign acc_load = (in_exec && ctl.cls == CL_MEM && !ctl.store)
                   || (state == ST_OPND);

    always_comb begin
        mem_addr = pc_q;
        case (state)
            ST_EXEC: begin
                case (ctl.cls)
                    CL_MEM:   mem_addr = ir_q.field;
                    CL_INDEX: mem_addr = base_addr;
                    CL_JUMP:  mem_addr = take_jump ? ir_q.field : pc_q;
                    default:  mem_addr = pc_q;
                endcase
            end
            ST_PTR_IDX: mem_addr = idx_addr;
            ST_OPND:    mem_addr = ptr_q;
            default:    mem_addr = pc_q;
        endcase
    end

    assign mem_we    = in_exec && (ctl.cls == CL_MEM) && ctl.store;
    assign mem_wdata = acc_q;
    assign halted    = (state == ST_HALT);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ir_q  <= '0;
        end else if (fetch_now) begin
            ir_q  <= instr_t'(mem_rdata);
            pc_q  <= mem_addr + addr_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           acc_q <= '0;
        else if (acc_load) acc_q <= alu_y;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (in_exec && ctl.cls == CL_INDEX)
            ptr_q <= mem_rdata[ADDR_W-1:0];
        else if (state == ST_PTR_IDX)
            ptr_q <= ptr_q + mem_rdata[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)                  cnt_q <= '0;
        else if (state != ST_HALT) cnt_q <= cnt_q + 1'b1;
    end

    assign cycle_count = cnt_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [11:0]      mem_addr,
    input logic [15:0]      mem_wdata,
    input logic             mem_we,
    input logic             halted,
    input logic [CNT_W-1:0] cycle_count,
    input logic [15:0]      ir_word,
    input logic [15:0]      acc_val,
    input logic             in_exec
);
    // R1
    first_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_addr == 12'd0 && !mem_we));

    // R3
    store_data_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_wdata == acc_val);

    // R3
    store_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R5
    ifpos_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ir_word[15:12] == 4'b0101 && !acc_val[15])
        |-> mem_addr == ir_word[11:0]);

    // R6
    goto_chk: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ir_word[15:12] == 4'b0100) |-> mem_addr == ir_word[11:0]);

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(cycle_count) && $stable(mem_addr)));

    // R7
    halt_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we);

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !halted |=> cycle_count == CNT_W'($past(cycle_count) + 1'b1));
endmodule

bind acc_core acc_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_we      (mem_we),
    .halted      (halted),
    .cycle_count (cycle_count),
    .ir_word     (ir_q),
    .acc_val     (acc_q),
    .in_exec     (in_exec)
);

// File: tb/acc_core_test.sv
module acc_core_test;
    localparam int CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [11:0]      mem_addr;
    logic [15:0]      mem_wdata;
    logic             mem_we;
    logic [15:0]      mem_rdata;
    logic             halted;
    logic [CNT_W-1:0] cycle_count;

    logic [15:0] mem [256];

    typedef struct {
        logic [11:0] a;
        logic [15:0] d;
        string       tag;
    } st_item_t;

    st_item_t exp_q[$];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    acc_core #(.CNT_W(CNT_W)) uut (
        .clk         (clk),
        .rst         (rst),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_we      (mem_we),
        .mem_rdata   (mem_rdata),
        .halted      (halted),
        .cycle_count (cycle_count)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [11:0] a, input logic [15:0] d, input string tag);
        st_item_t it;
        it.a = a; it.d = d; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // monitor: compares every store against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3", "unexpected store", longint'(mem_addr), 0);
            end else begin
                st_item_t it;
                it = exp_q.pop_front();
                check(mem_addr == it.a, it.tag, "store address", longint'(mem_addr), longint'(it.a));
                check(mem_wdata == it.d, it.tag, "store data", longint'(mem_wdata), longint'(it.d));
            end
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst = 1'b1;
        exp_q.delete();
        clear_mem();
    endtask

    // releases reset, waits for halt, checks cost and the frozen state
    task automatic run_prog(input int exp_cycles, input string tag);
        logic [11:0]      a0;
        logic [CNT_W-1:0] c0;
        int               guard;
        repeat (2) @(negedge clk);
        // R1 reset state
        check(!halted && cycle_count == 0 && !mem_we, "R1", "reset outputs",
              longint'({halted, mem_we, cycle_count[7:0]}), 0);
        rst = 1'b0;
        #1;
        check(mem_addr == 12'd0 && !mem_we, "R1", "first fetch address",
              longint'(mem_addr), 0);
        guard = 0;
        @(negedge clk);
        while (!halted && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(halted, "R7", {tag, " halted"}, longint'(halted), 1);
        check(cycle_count == CNT_W'(exp_cycles), "R10", {tag, " cycle total"},
              longint'(cycle_count), longint'(exp_cycles));
        check(exp_q.size() == 0, tag, "stores missing", longint'(exp_q.size()), 0);
        a0 = mem_addr;
        c0 = cycle_count;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(halted && !mem_we && mem_addr == a0 && cycle_count == c0, "R7",
                  "frozen after stop", longint'(cycle_count), longint'(c0));
        end
    endtask

    // R2 R4 R5: two-way select, taken path
    task automatic prog_select(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] c;
        int          cyc;
        enter_reset();
        mem[0]  = enc(4'b0000, 12'd20);
        mem[1]  = enc(4'b0011, 12'd21);
        mem[2]  = enc(4'b0101, 12'd8);
        mem[3]  = enc(4'b0000, 12'd21);
        mem[4]  = enc(4'b0011, 12'd20);
        mem[5]  = enc(4'b0011, 12'd24);
        mem[6]  = enc(4'b0001, 12'd22);
        mem[7]  = enc(4'b0111, 12'd0);
        mem[8]  = enc(4'b0010, 12'd23);
        mem[9]  = enc(4'b0001, 12'd22);
        mem[10] = enc(4'b0111, 12'd0);
        mem[20] = a; mem[21] = b; mem[23] = 16'd1; mem[24] = 16'd2;
        if (!((a - b) >> 15)) begin
            c = a - b + 16'd1;
            cyc = 11;
        end else begin
            c = b - a - 16'd2;
            cyc = 15;
        end
        push(12'd22, c, "R4 R5 select");
        run_prog(cyc, "R5 select");
    endtask

    // R4: counting loop, 1 + 2 + ... + 99
    task automatic prog_loop();
        logic [15:0] sum;
        enter_reset();
        mem[0]  = enc(4'b0000, 12'd20);
        mem[1]  = enc(4'b0001, 12'd17);
        mem[2]  = enc(4'b0010, 12'd21);
        mem[3]  = enc(4'b0001, 12'd16);
        mem[4]  = enc(4'b0000, 12'd16);
        mem[5]  = enc(4'b0011, 12'd22);
        mem[6]  = enc(4'b0101, 12'd15);
        mem[7]  = enc(4'b0000, 12'd16);
        mem[8]  = enc(4'b0010, 12'd17);
        mem[9]  = enc(4'b0001, 12'd17);
        mem[10] = enc(4'b0000, 12'd16);
        mem[11] = enc(4'b0010, 12'd21);
        mem[12] = enc(4'b0001, 12'd16);
        mem[13] = enc(4'b0101, 12'd4);
        mem[15] = enc(4'b0111, 12'd0);
        mem[20] = 16'd0; mem[21] = 16'd1; mem[22] = 16'd100;
        push(12'd17, 16'd0, "R3 init sum");
        push(12'd16, 16'd1, "R3 init i");
        sum = 16'd0;
        for (int i = 1; i < 100; i++) begin
            sum = sum + 16'(i);
            push(12'd17, sum, "R4 loop sum");
            push(12'd16, 16'(i + 1), "R4 loop index");
        end
        run_prog(1797, "R4 loop");
    endtask

    // R6 R8 R9: jumps, no-op and indexed add
    task automatic prog_misc();
        enter_reset();
        mem[0]  = enc(4'b0000, 12'd30);
        mem[1]  = enc(4'b0110, 12'd9);
        mem[2]  = enc(4'b0100, 12'd5);
        mem[3]  = enc(4'b0111, 12'd0);
        mem[4]  = enc(4'b0111, 12'd0);
        mem[5]  = enc(4'b0000, 12'd31);
        mem[6]  = enc(4'b0110, 12'd8);
        mem[7]  = enc(4'b0111, 12'd0);
        mem[8]  = enc(4'b0101, 12'd3);
        mem[9]  = enc(4'b1010, 12'hABC);
        mem[10] = enc(4'b1000, {6'd32, 6'd33});
        mem[11] = enc(4'b0001, 12'd34);
        mem[12] = enc(4'b0111, 12'd0);
        mem[30] = 16'h0000; mem[31] = 16'h8001;
        mem[32] = 16'd40; mem[33] = 16'd5; mem[45] = 16'h0100;
        push(12'd34, 16'h8101, "R8 R9 R6 result");
        run_prog(17, "R6 R8 R9 misc");
    endtask

    // R8: base plus index wraps in the 12-bit address
    task automatic prog_index_wrap();
        enter_reset();
        mem[0]  = enc(4'b1000, {6'd20, 6'd21});
        mem[1]  = enc(4'b0001, 12'd22);
        mem[2]  = enc(4'b0111, 12'd0);
        mem[20] = 16'hFFFE; mem[21] = 16'h0031; mem[47] = 16'h1234;
        push(12'd22, 16'h1234, "R8 wrapped index");
        run_prog(8, "R8 index");
    endtask

    // R7: stop at address 0
    task automatic prog_stop();
        enter_reset();
        mem[0] = enc(4'b0111, 12'd0);
        run_prog(2, "R7 stop");
    endtask

    initial begin
        prog_select(16'd7, 16'd3);
        prog_select(16'd3, 16'd7);
        prog_select(16'hFFFB, 16'h7FFF);
        prog_loop();
        prog_misc();
        prog_index_wrap();
        prog_stop();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected halt");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule